// File: doc/BRIEF.md
# Shift-Add Signed Multiply-Accumulate Sequencer

This block is a sequential multiply-accumulate unit. Each operation takes a signed multiplier word, a signed multiplicand word, a double-width accumulator value and a direction bit. It forms the signed double-width product one bit per cycle. Each cycle it adds either the multiplier or zero to a running high half, then shifts one bit into a low-half register. The step for the multiplicand's top bit subtracts instead of adding, which gives two's-complement weighting. The product then goes into the accumulator value, added or subtracted. The first step forces the running high half to zero, so there is no separate clear cycle.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream. The input side accepts a word when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the unit is idle, so a new operand set waits until the previous result has been taken. The output side presents a result with `out_valid` and holds it, unchanged, until a clock edge sees `out_ready` high. A step counter drives `step_cnt`, and a plain control pin, `step_last`, marks the accumulate cycle that ends a multiply.

Top module: `shiftadd_mac`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only while no operation is running or waiting on the output, so `in_ready` and `out_valid` are never both 1.
- R2: The step counter `step_cnt` is 0 while idle. It is 0 in the cycle after an accept and rises by one each cycle through 0..W. After W it wraps to 0.
- R3: `step_last` is 1 exactly in the cycle where the running counter equals W, and in no other cycle.
- R4: `out_valid` becomes 1 exactly W+1 clock edges after the accepting edge.
- R5: With `in_sub` = 0 the result is `in_acc` plus the signed product of `in_mplier` and `in_mcand`, modulo 2^(2W).
- R6: With `in_sub` = 1 the result is `in_acc` minus that signed product, modulo 2^(2W).
- R7: The product is correct when either operand or both are the most negative W-bit value. This needs the subtraction on the final step.
- R8: No state from an earlier operation affects a later result. The product is cleared by the first step's zero gating.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_acc` stays unchanged. After the edge that takes the result, `out_valid` is 0 and `in_ready` is 1.
- R10: Operands are captured at the accepting edge. Changing the input data pins or `in_valid` while an operation runs has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit idle, operand set will be taken |
| in_mplier | input | W | Signed multiplier word |
| in_mcand | input | W | Signed multiplicand word, consumed LSB first |
| in_acc | input | 2W | Accumulator value to combine with the product |
| in_sub | input | 1 | 0: add product, 1: subtract product |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_acc | output | 2W | Updated accumulator |
| step_cnt | output | $clog2(W+1) | Multiply step counter |
| step_last | output | 1 | Counter has reached W: accumulate cycle |

## Verification
The bench goes after operands at the most negative value, in either position and both together. A design that added the top multiplicand bit instead of subtracting it would return products off by the multiplier times 2^W. It runs operations back to back with no idle gap. If the first-step zero gating were missing, the previous product would leak into the next result. It scrambles the input pins during each run and holds `out_ready` low for several cycles. A unit that read live inputs, or let its result drift while stalled, would then produce a mismatch. It also traces `step_cnt` and `step_last` cycle by cycle, which exposes a counter that stops short, overshoots W or fails to wrap.

// File: rtl/shiftadd_mac_pkg.sv
package shiftadd_mac_pkg;

  typedef enum logic [1:0] {
    MAC_IDLE = 2'd0,
    MAC_RUN  = 2'd1,
    MAC_HOLD = 2'd2
  } mac_state_t;

endpackage

// File: rtl/mac_step_ctr.sv
module mac_step_ctr #(
  parameter int LAST = 16,
  parameter int CW   = $clog2(LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  localparam logic [CW-1:0] LAST_CNT = CW'(LAST);

  assign at_last = (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (inc) begin
      if (at_last) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mac_step_dp.sv
module mac_step_dp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_mplier,
  input  logic [W-1:0] ld_mcand,
  input  logic         step,
  input  logic         first,
  input  logic         last,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  logic [W-1:0] mplier_q;
  logic [W-1:0] mcand_sh;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;

  logic [W:0] hi_ext;
  logic [W:0] pp_ext;
  logic [W:0] sum;
  logic       do_sub;

  always_comb begin
    hi_ext = first ? '0 : {hi_q[W-1], hi_q};
    pp_ext = mcand_sh[0] ? {mplier_q[W-1], mplier_q} : '0;
    do_sub = last && mcand_sh[0];
    sum    = do_sub ? (hi_ext - pp_ext) : (hi_ext + pp_ext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mplier_q <= '0;
      mcand_sh <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (load) begin
      mplier_q <= ld_mplier;
      mcand_sh <= ld_mcand;
    end else if (step) begin
      hi_q     <= sum[W:1];
      lo_q     <= {sum[0], lo_q[W-1:1]};
      mcand_sh <= {1'b0, mcand_sh[W-1:1]};
    end
  end

  assign prod_hi = hi_q;
  assign prod_lo = lo_q;

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [2*W-1:0] ld_acc,
  input  logic           ld_sub,
  input  logic           fire,
  input  logic [2*W-1:0] prod,
  output logic [2*W-1:0] result
);

  logic [2*W-1:0] acc_q;
  logic           sub_q;
  logic [2*W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      sub_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (load) begin
        acc_q <= ld_acc;
        sub_q <= ld_sub;
      end
      if (fire) res_q <= sub_q ? (acc_q - prod) : (acc_q + prod);
    end
  end

  assign result = res_q;

endmodule

// File: rtl/shiftadd_mac.sv
module shiftadd_mac #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_mplier,
  input  logic [W-1:0]   in_mcand,
  input  logic [2*W-1:0] in_acc,
  input  logic           in_sub,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_acc,
  output logic [CW-1:0]  step_cnt,
  output logic           step_last
);
  import shiftadd_mac_pkg::*;

  localparam logic [CW-1:0] FINAL_STEP = CW'(W - 1);

  mac_state_t state_q;
  logic       accept;
  logic       running;
  logic       cnt_last;
  logic [W-1:0] prod_hi;
  logic [W-1:0] prod_lo;

  assign accept    = in_valid && (state_q == MAC_IDLE);
  assign running   = (state_q == MAC_RUN);
  assign in_ready  = (state_q == MAC_IDLE);
  assign out_valid = (state_q == MAC_HOLD);
  assign step_last = running && cnt_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MAC_IDLE;
    end else begin
      unique case (state_q)
        MAC_IDLE: if (in_valid)  state_q <= MAC_RUN;
        MAC_RUN:  if (cnt_last)  state_q <= MAC_HOLD;
        MAC_HOLD: if (out_ready) state_q <= MAC_IDLE;
        default:                 state_q <= MAC_IDLE;
      endcase
    end
  end

  mac_step_ctr #(.LAST(W), .CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .inc     (running),
    .cnt     (step_cnt),
    .at_last (cnt_last)
  );

  mac_step_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ld_mplier (in_mplier),
    .ld_mcand  (in_mcand),
    .step      (running && !cnt_last),
    .first     (step_cnt == '0),
    .last      (step_cnt == FINAL_STEP),
    .prod_hi   (prod_hi),
    .prod_lo   (prod_lo)
  );

  mac_acc_unit #(.W(W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .ld_acc (in_acc),
    .ld_sub (in_sub),
    .fire   (step_last),
    .prod   ({prod_hi, prod_lo}),
    .result (out_acc)
  );

endmodule

// File: rtl/shiftadd_mac_chk.sv
module shiftadd_mac_chk #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_acc,
  input logic [CW-1:0]  step_cnt,
  input logic           step_last
);

  localparam logic [CW-1:0] TOP = CW'(W);

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R1

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt == TOP) |=> (step_cnt == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt != '0 && step_cnt != TOP) |=> (step_cnt == $past(step_cnt) + 1'b1)); // R2

  AST_LAST_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |-> (step_cnt == TOP)); // R3

  AST_LAST_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> $rose(out_valid)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc))); // R9

  AST_TAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R9

endmodule

bind shiftadd_mac shiftadd_mac_chk #(.W(W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_acc   (out_acc),
  .step_cnt  (step_cnt),
  .step_last (step_last)
);

// File: tb/shiftadd_mac_test.sv
`timescale 1ns/1ps
module shiftadd_mac_test;
  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_mplier = '0;
  logic [W-1:0]   in_mcand = '0;
  logic [2*W-1:0] in_acc = '0;
  logic           in_sub = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [2*W-1:0] out_acc;
  logic [CW-1:0]  step_cnt;
  logic           step_last;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shiftadd_mac #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mplier(in_mplier), .in_mcand(in_mcand), .in_acc(in_acc), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready), .out_acc(out_acc),
    .step_cnt(step_cnt), .step_last(step_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2*W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [2*W-1:0] acc, bit sub);
    logic signed [2*W-1:0] p;
    p = $signed(a) * $signed(b);
    return sub ? (acc - p) : (acc + p);
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2*W-1:0] acc, input bit sub, input int stall);
    logic [2*W-1:0] exp;
    logic [2*W-1:0] held;
    exp = model(a, b, acc, sub);
    chk(in_ready === 1'b1, "R1 ready before offer", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_mplier = a; in_mcand = b; in_acc = acc; in_sub = sub;
    @(posedge clk);
    @(negedge clk);
    // R10: scramble inputs while the operation runs
    in_valid = 1'($urandom); in_mplier = W'($urandom); in_mcand = W'($urandom);
    in_acc = {$urandom, $urandom} >> (64 - 2*W); in_sub = 1'($urandom);
    for (int k = 0; k <= W; k++) begin
      chk(step_cnt == CW'(k), "R2 step count", 64'(step_cnt), 64'(k));
      chk(step_last == (k == W), "R3 step_last", 64'(step_last), 64'(k == W));
      chk(out_valid == 1'b0 && in_ready == 1'b0, "R4 busy no valid",
          64'({out_valid, in_ready}), 64'd0);
      @(negedge clk);
    end
    chk(out_valid === 1'b1, "R4 valid after W+1 edges", 64'(out_valid), 64'd1);
    chk(step_cnt == '0, "R2 wrap to 0", 64'(step_cnt), 64'd0);
    chk(out_acc === exp, sub ? "R6 R10 subtract result" : "R5 R10 add result",
        64'(out_acc), 64'(exp));
    in_valid = 1'b0;
    held = out_acc;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_acc === held, "R9 hold while stalled",
          64'(out_acc), 64'(held));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 release after take",
        64'({out_valid, in_ready}), 64'b01);
  endtask

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
        64'({in_ready, out_valid}), 64'b10);
    chk(step_cnt == '0 && step_last == 1'b0, "R2 idle count",
        64'({step_cnt, step_last}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 after reset release",
        64'({in_ready, out_valid}), 64'b10);
    // directed corners (R7)
    run_op(MINV, MINV, '0, 1'b0, 0);
    run_op(MINV, MAXV, '0, 1'b0, 2);
    run_op(MAXV, MINV, 32'h1234_5678, 1'b1, 0);
    run_op(MINV, W'(1), '0, 1'b0, 1);
    run_op(W'(-1), W'(-1), 32'hFFFF_FFFF, 1'b0, 0);
    run_op(MAXV, MAXV, '0, 1'b1, 3);
    // R8: zero product straight after a large one
    run_op(MINV, MINV, '0, 1'b0, 0);
    run_op(W'(0), W'(-1), 32'hCAFE_0001, 1'b0, 0);
    run_op(W'(7), W'(0), 32'h8000_0000, 1'b1, 0);
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      if ($urandom_range(0, 9) == 0) a = MINV;
      if ($urandom_range(0, 9) == 0) b = MINV;
      run_op(a, b, {$urandom, $urandom} >> (64 - 2*W), 1'($urandom),
             $urandom_range(0, 3));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule